// File: doc/BRIEF.md
# Banked Scratchpad Read Arbiter

This block serves one load request per cycle from a warp of 32 lanes. Each lane supplies a byte address and an active bit. The block reads from an on-chip scratchpad that is split into 32 banks. In each pass it finds a group of pending lanes whose reads do not collide in any bank, reads all of them at once, and returns their data with a per-lane valid mask. Lanes that name the same word share one read, which is broadcast to all of them. Only lanes that name different words in the same bank push work into later passes. A done pulse marks the pass that completes the request.

A run-time mode input sets the bank word size to 32 or 64 bits. The mode changes where addresses fall among the banks and how wide the returned data is. The scratchpad is a behavioural array that is filled with a fixed pattern at reset. There is no write path. While a request still has passes after the current one, the block drops its ready output. In the final pass ready is high again, so a new request can be accepted in that same cycle.

Top module: `sp_bank_arbiter`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is all zero and rsp_done is 0.
- R2: With wide_mode=0, a served lane with address A gets low half 0x5A000000|(A>>2) and upper half 0. The scratchpad word w holds 0x5A000000|w. Lane i's data is on rsp_data[64i+63:64i].
- R3: With wide_mode=1, a served lane with address A gets low half 0x5A000000|(2*(A>>3)) and high half 0x5A000000|(2*(A>>3)+1).
- R4: The word index is A>>2 in narrow mode and A>>3 in wide mode. The bank is the word index mod 32. Active lanes whose banks are all different are served in a single pass.
- R5: Lanes that name the same word are served in the same pass from one broadcast read. If every lane uses one address, the request takes one pass.
- R6: In each pass, the lowest-numbered pending lane of a bank chooses that bank's word. Every pending lane that names a chosen word is served in that pass. The remaining lanes wait for later passes.
- R7: A request takes exactly as many passes as the largest number of distinct words that active lanes name within any one bank. Every pass except an empty request's single pass serves at least one lane.
- R8: req_ready is 1 when the block is idle and in the cycle of a request's final pass. It is 0 in every other cycle of a request that is being served.
- R9: A request accepted at edge k shows its first pass result after edge k+1, and one pass follows per cycle after that. Each active lane is reported valid exactly once. rsp_done is 1 only together with the final pass mask.
- R10: Inactive lanes are never reported valid. A request with no active lanes gives one result with rsp_done=1 and an all-zero mask.
- R11: Address bits below the word size (two bits in narrow mode, three bits in wide mode) do not affect banking, conflicts or data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the scratchpad |
| wide_mode | input | 1 | 0: 32-bit bank words, 1: 64-bit bank words; change only while idle |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_active | input | 32 | Per-lane active bits |
| req_addr | input | 320 | Per-lane byte addresses, 10 bits each, lane i at [10i+9:10i] |
| rsp_valid | output | 32 | Lanes served by the pass shown this cycle |
| rsp_data | output | 2048 | Per-lane read data, 64 bits each |
| rsp_done | output | 1 | The pass shown completes the request |

## Verification
A corrupted pending mask has two visible effects, both seen within the passes of the same request. It either reports a lane valid a second time, or it raises done while an active lane has never been reported. A bad winner or bank computation changes the number of result cycles, or which lanes appear in the first pass, or the data a lane returns. The pass count and the first-pass mask are therefore compared against the independently computed values on every request. A stuck busy state shows up one cycle after acceptance as a ready level that does not match the remaining pass count.

// File: rtl/sp_pkg.sv
package sp_pkg;
   typedef enum logic {
      SP_NARROW = 1'b0,
      SP_WIDE   = 1'b1
   } sp_mode_e;

   localparam logic [31:0] SP_FILL_TAG = 32'h5A00_0000;

   function automatic logic [31:0] sp_fill(input int unsigned idx);
      sp_fill = SP_FILL_TAG | 32'(idx);
   endfunction
endpackage

// File: rtl/sp_lane_map.sv
module sp_lane_map #(
   parameter int LANES   = 32,
   parameter int ADDR_W  = 10,
   parameter int BANK_W  = 5,
   parameter bit WIDE_EN = 1'b1,
   localparam int WIDX_W = ADDR_W - 2
) (
   input  logic                               wide_mode,
   input  logic [LANES-1:0][ADDR_W-1:0]       lane_addr,
   output logic [LANES-1:0][WIDX_W-1:0]       lane_word,
   output logic [LANES-1:0][BANK_W-1:0]       lane_bank
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (WIDE_EN) begin : g_dual
         assign lane_word[i] = wide_mode ? {1'b0, lane_addr[i][ADDR_W-1:3]}
                                         : lane_addr[i][ADDR_W-1:2];
      end else begin : g_narrow
         assign lane_word[i] = lane_addr[i][ADDR_W-1:2];
      end
      assign lane_bank[i] = lane_word[i][BANK_W-1:0];
   end
endmodule

// File: rtl/sp_pass_select.sv
module sp_pass_select #(
   parameter int LANES  = 32,
   parameter int BANK_W = 5,
   parameter int WIDX_W = 8
) (
   input  logic [LANES-1:0]                pending,
   input  logic [LANES-1:0][WIDX_W-1:0]    lane_word,
   input  logic [LANES-1:0][BANK_W-1:0]    lane_bank,
   output logic [LANES-1:0]                serve
);
   logic [LANES-1:0] lead;

   // a lane leads its bank when no lower pending lane uses that bank
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         lead[i] = pending[i];
         for (int j = 0; j < LANES; j++) begin
            if (j < i && pending[j] && lane_bank[j] == lane_bank[i]) lead[i] = 1'b0;
         end
      end
   end

   // a pending lane is served when some leader names the same word
   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         serve[i] = 1'b0;
         for (int j = 0; j < LANES; j++) begin
            if (lead[j] && pending[i] && lane_word[j] == lane_word[i]) serve[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sp_store.sv
module sp_store
   import sp_pkg::*;
#(
   parameter int LANES  = 32,
   parameter int WIDX_W = 8,
   localparam int WORDS = 1 << WIDX_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wide_mode,
   input  logic [LANES-1:0][WIDX_W-1:0]     lane_word,
   input  logic [LANES-1:0]                 serve,
   output logic [LANES-1:0][63:0]           lane_data
);
   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < WORDS; k++) mem[k] <= sp_fill(k);
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_rd
      logic [WIDX_W-1:0] lo_idx;
      logic [WIDX_W-1:0] hi_idx;
      assign lo_idx = {lane_word[i][WIDX_W-2:0], 1'b0};
      assign hi_idx = {lane_word[i][WIDX_W-2:0], 1'b1};
      always_comb begin
         if (!serve[i])       lane_data[i] = '0;
         else if (wide_mode)  lane_data[i] = {mem[hi_idx], mem[lo_idx]};
         else                 lane_data[i] = {32'h0, mem[lane_word[i]]};
      end
   end
endmodule

// File: rtl/sp_bank_arbiter.sv
module sp_bank_arbiter #(
   parameter int LANES   = 32,
   parameter int ADDR_W  = 10,
   parameter int BANK_W  = 5,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wide_mode,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [LANES-1:0]          req_active,
   input  logic [LANES*ADDR_W-1:0]   req_addr,
   output logic [LANES-1:0]          rsp_valid,
   output logic [LANES*64-1:0]       rsp_data,
   output logic                      rsp_done
);
   localparam int WIDX_W = ADDR_W - 2;

   if (ADDR_W < BANK_W + 3) begin : g_bad_addr
      $error("ADDR_W must cover bank bits plus the wide word offset");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be positive");
   end

   logic                               busy_q;
   logic [LANES-1:0]                   pend_q;
   logic [LANES-1:0][ADDR_W-1:0]       addr_q;
   logic [LANES-1:0][ADDR_W-1:0]       addr_in;
   logic [LANES-1:0][WIDX_W-1:0]       lane_word;
   logic [LANES-1:0][BANK_W-1:0]       lane_bank;
   logic [LANES-1:0]                   serve;
   logic [LANES-1:0]                   left;
   logic [LANES-1:0][63:0]             lane_data;
   logic [LANES-1:0][63:0]             data_q;
   logic                               wide_eff;
   logic                               last_pass;
   logic                               accept;

   assign wide_eff  = WIDE_EN ? wide_mode : 1'b0;
   assign addr_in   = req_addr;
   assign left      = pend_q & ~serve;
   assign last_pass = busy_q && (left == '0);
   assign req_ready = !busy_q || last_pass;
   assign accept    = req_valid && req_ready;

   sp_lane_map #(.LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIDE_EN(WIDE_EN)) u_map (
      .wide_mode (wide_eff),
      .lane_addr (addr_q),
      .lane_word (lane_word),
      .lane_bank (lane_bank)
   );

   sp_pass_select #(.LANES(LANES), .BANK_W(BANK_W), .WIDX_W(WIDX_W)) u_sel (
      .pending   (pend_q),
      .lane_word (lane_word),
      .lane_bank (lane_bank),
      .serve     (serve)
   );

   sp_store #(.LANES(LANES), .WIDX_W(WIDX_W)) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide_mode (wide_eff),
      .lane_word (lane_word),
      .serve     (serve),
      .lane_data (lane_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_q <= '0;
         addr_q <= '0;
      end else if (accept) begin
         busy_q <= 1'b1;
         pend_q <= req_active;
         addr_q <= addr_in;
      end else if (busy_q) begin
         busy_q <= !last_pass;
         pend_q <= left;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= '0;
         rsp_done  <= 1'b0;
         data_q    <= '0;
      end else begin
         rsp_valid <= busy_q ? serve : '0;
         rsp_done  <= last_pass;
         data_q    <= lane_data;
      end
   end

   assign rsp_data = data_q;
endmodule

// File: rtl/sp_bank_arbiter_chk.sv
module sp_bank_arbiter_chk #(
   parameter int LANES  = 32,
   parameter int ADDR_W = 10
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wide_mode,
   input logic                    req_valid,
   input logic                    req_ready,
   input logic [LANES-1:0]        req_active,
   input logic [LANES-1:0]        rsp_valid,
   input logic [LANES*64-1:0]     rsp_data,
   input logic                    rsp_done
);
   logic [LANES-1:0] act_q;
   logic [LANES-1:0] act_out;
   logic [LANES-1:0] acc_q;
   logic             hi_any;

   always_comb begin
      hi_any = 1'b0;
      for (int i = 0; i < LANES; i++) hi_any = hi_any | (|rsp_data[64*i+32 +: 32]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= '0;
         act_out <= '0;
         acc_q   <= '0;
      end else begin
         if (req_valid && req_ready) act_q <= req_active;
         act_out <= act_q;
         acc_q   <= rsp_done ? '0 : (acc_q | rsp_valid);
      end
   end

   assert_only_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid & ~act_out) == '0);

   assert_served_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid & acc_q) == '0);

   assert_done_complete_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> ((acc_q | rsp_valid) == act_out));

   assert_ready_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(req_ready));

   assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_mode && $stable(wide_mode)) |-> !hi_any);
endmodule

bind sp_bank_arbiter sp_bank_arbiter_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wide_mode  (wide_mode),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_active (req_active),
   .rsp_valid  (rsp_valid),
   .rsp_data   (rsp_data),
   .rsp_done   (rsp_done)
);

// File: tb/sim_sp_bank_arbiter.sv
module sim_sp_bank_arbiter;
   localparam int LANES  = 32;
   localparam int ADDR_W = 10;

   typedef struct packed {
      logic        wide;
      logic [31:0] act;
      logic [9:0]  base;
      logic [9:0]  stride;
      logic [7:0]  passes;
      logic [3:0]  tag;
   } vec_t;

   // pass counts worked out by hand from R4..R7, R10, R11
   localparam vec_t VECS [11] = '{
      '{1'b0, 32'hFFFF_FFFF, 10'd0,   10'd4,   8'd1, 4'd4},   // distinct banks
      '{1'b0, 32'hFFFF_FFFF, 10'd40,  10'd0,   8'd1, 4'd5},   // one address
      '{1'b0, 32'hFFFF_FFFF, 10'd0,   10'd128, 8'd8, 4'd7},   // bank 0, 8 words
      '{1'b0, 32'hFFFF_FFFF, 10'd0,   10'd8,   8'd2, 4'd7},   // two words per bank
      '{1'b1, 32'hFFFF_FFFF, 10'd0,   10'd8,   8'd1, 4'd4},   // wide, distinct banks
      '{1'b1, 32'hFFFF_FFFF, 10'd0,   10'd4,   8'd1, 4'd5},   // wide, pairs share
      '{1'b1, 32'hFFFF_FFFF, 10'd0,   10'd256, 8'd4, 4'd7},   // wide, bank 0, 4 words
      '{1'b0, 32'h0000_000F, 10'd0,   10'd128, 8'd4, 4'd10},  // only 4 lanes active
      '{1'b0, 32'h0000_0000, 10'd0,   10'd4,   8'd1, 4'd10},  // empty request
      '{1'b0, 32'hFFFF_FFFF, 10'd0,   10'd1,   8'd1, 4'd11},  // byte offsets
      '{1'b0, 32'hFFFF_FFFF, 10'd3,   10'd132, 8'd1, 4'd11}   // skewed, offset 3
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wide_mode = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [LANES-1:0] req_active = '0;
   logic [LANES-1:0][ADDR_W-1:0] addr_drv = '0;
   logic [LANES-1:0] rsp_valid;
   logic [LANES*64-1:0] rsp_data;
   logic rsp_done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sp_bank_arbiter #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .wide_mode  (wide_mode),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_active (req_active),
      .req_addr   (addr_drv),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .rsp_done   (rsp_done)
   );

   function automatic string tag_name(input logic [3:0] t);
      case (t)
         4'd4:    tag_name = "R4";
         4'd5:    tag_name = "R5";
         4'd10:   tag_name = "R10";
         4'd11:   tag_name = "R11";
         default: tag_name = "R7";
      endcase
   endfunction

   function automatic logic [63:0] exp_data(input logic wide, input logic [9:0] a);
      int unsigned w;
      if (wide) begin
         w = 32'(a >> 3);
         exp_data = {32'h5A00_0000 | 32'(2*w+1), 32'h5A00_0000 | 32'(2*w)};
      end else begin
         w = 32'(a >> 2);
         exp_data = {32'h0, 32'h5A00_0000 | 32'(w)};
      end
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] actual,
                        input logic [63:0] expect_v);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, actual, expect_v);
      end
   endtask

   task automatic run_req(input logic wide, input logic [31:0] act,
                          input logic [LANES-1:0][ADDR_W-1:0] addrs,
                          input int exp_passes, input string tag,
                          input bit chk_first, input logic [31:0] first_mask);
      logic [31:0] served = '0;
      logic [31:0] mask;
      logic [63:0] ev;
      bit prev_ready;
      bit got_done = 1'b0;
      int passes = 0;
      @(negedge clk);
      wide_mode  = wide;
      req_active = act;
      addr_drv   = addrs;
      req_valid  = 1'b1;
      check(req_ready == 1'b1, "R8 idle ready", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid  = 1'b0;
      prev_ready = req_ready;
      if (exp_passes > 1) check(req_ready == 1'b0, "R8 busy ready", 64'(req_ready), 64'd0);
      for (int c = 0; c < 80 && !got_done; c++) begin
         @(negedge clk);
         passes++;
         mask = rsp_valid;
         if (passes == 1 && chk_first)
            check(mask == first_mask, "R6 first pass mask", 64'(mask), 64'(first_mask));
         check((mask & ~act) == '0, "R10 inactive lane valid", 64'(mask), 64'(act));
         check((mask & served) == '0, "R9 lane repeated", 64'(mask), 64'(served));
         for (int i = 0; i < LANES; i++) begin
            if (mask[i]) begin
               ev = exp_data(wide, addrs[i]);
               check(rsp_data[64*i +: 64] == ev, wide ? "R3 wide data" : "R2 narrow data",
                     rsp_data[64*i +: 64], ev);
            end
         end
         served |= mask;
         if (rsp_done) begin
            got_done = 1'b1;
            check(prev_ready == 1'b1, "R8 ready in final pass", 64'(prev_ready), 64'd1);
         end else begin
            check(prev_ready == 1'b0, "R8 ready mid request", 64'(prev_ready), 64'd0);
            check(mask != '0, "R7 empty middle pass", 64'(mask), 64'd1);
         end
         prev_ready = req_ready;
      end
      check(got_done, "R9 done seen", 64'(got_done), 64'd1);
      check(served == act, "R9 all active served", 64'(served), 64'(act));
      check(passes == exp_passes, tag, 64'(passes), 64'(exp_passes));
   endtask

   initial begin
      #(10 * 200000);
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [LANES-1:0][ADDR_W-1:0] a;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
      check(rsp_valid == '0, "R1 reset mask", 64'(rsp_valid), 64'd0);
      check(rsp_done == 1'b0, "R1 reset done", 64'(rsp_done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && rsp_valid == '0 && !rsp_done, "R1 after reset",
            {rsp_valid, 31'h0, req_ready}, 64'd1);

      for (int v = 0; v < 11; v++) begin
         for (int i = 0; i < LANES; i++)
            a[i] = 10'(32'(VECS[v].base) + 32'(VECS[v].stride) * i);
         run_req(VECS[v].wide, VECS[v].act, a, int'(VECS[v].passes),
                 tag_name(VECS[v].tag), 1'b0, '0);
      end

      // R6: lanes 0 and 2 share word 0, lane 1 needs word 32 of the same bank
      a = '0;
      a[1] = 10'd128;
      run_req(1'b0, 32'h7, a, 2, "R6 pass count", 1'b1, 32'h5);

      // R6: lane 1 leads bank 0 once lane 0 is inactive
      run_req(1'b0, 32'h6, a, 2, "R6 pass count", 1'b1, 32'h2);

      // R11: wide mode ignores three low bits
      for (int i = 0; i < LANES; i++) a[i] = 10'(8 * i + (i % 8));
      run_req(1'b1, 32'hFFFF_FFFF, a, 1, "R11 wide offset", 1'b1, 32'hFFFF_FFFF);

      // R4: all lanes on word 5 except lane 31 on word 37 of bank 5
      for (int i = 0; i < LANES; i++) a[i] = 10'd20;
      a[31] = 10'd148;
      run_req(1'b0, 32'hFFFF_FFFF, a, 2, "R4 bank conflict", 1'b1, 32'h7FFF_FFFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule